// File: doc/BRIEF.md
# Launch-Capture Phase-Stepping Engine

This block runs one launch-capture event after the scan chains have been loaded. A start pulse latches a requested capture-clock phase. The engine first drives a flush-delay mode for a fixed number of cycles and latches the bit that comes out of the end of the capture row as a reference value. It then walks an internally tracked phase register toward the requested phase, one step at a time. Each step is a one-cycle adjust request with a direction bit, and the engine waits for the external clock manager to acknowledge it with a done pulse.

When the tracked phase equals the target, the engine routes the phase-shifted clock to the capture row. It fires a one-cycle launch enable and then a one-cycle capture enable, and returns to idle with `ready_o` high. The tracked phase is kept between runs, so a later run only walks the difference. Two external inputs can force the launch or capture enable on, so that scan shifting can clock those domains while the engine is idle.

Top module: `lc_phase_engine`

## Requirements
- R1: After a synchronous active-high reset, `ready_o` is 1, `ref_val_o` is 0, and `ps_en_o`, `flush_mode_o`, `cap_sel_o`, `launch_en_o` and `capture_en_o` are all 0 (with both ungate inputs low).
- R2: A `start_i` pulse seen in idle drops `ready_o` in the next cycle. `flush_mode_o` is then high for exactly FLUSH_WAIT consecutive cycles (default 128).
- R3: `ref_val_o` takes the value of `chain_tail_i` sampled in the last flush cycle. It holds that value until the end of the next flush.
- R4: Once the flush ends, each phase step is a `ps_en_o` pulse one cycle long, with `ps_inc_o` = 1 to increment when the target is above the tracked phase and 0 to decrement when it is below. No further step is issued until `ps_done_i` has been seen.
- R5: Stepping stops when the tracked phase equals the target, so one run issues exactly |target − previous phase| steps. A target equal to the current phase issues none. The tracked phase carries over to the next run.
- R6: A requested phase (10-bit unsigned) above PHASE_MAX (default 740) is treated as PHASE_MAX. Zero is zero phase.
- R7: After the phase is reached, `launch_en_o` is high for exactly one cycle and `capture_en_o` is high in the following cycle only. `cap_sel_o` (1 = shifted capture clock, 0 = unshifted launch clock) is 1 in exactly those two cycles.
- R8: `ready_o` returns to 1 in the cycle right after the capture-enable cycle.
- R9: A `start_i` pulse while `ready_o` is 0 is ignored. Neither its phase request nor the run in progress is affected.
- R10: `launch_ungate_i` forces `launch_en_o` to 1, and `capture_ungate_i` forces `capture_en_o` to 1, combinationally and independently.
- R11: Reset in the middle of a run returns the engine to idle and sets the tracked phase to 0, so the next run steps up from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (launch domain) |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, honoured only in idle |
| req_phase_i | input | 10 | Requested capture phase, unsigned |
| chain_tail_i | input | 1 | Bit at the end of the capture row |
| ps_done_i | input | 1 | Clock-manager step-complete pulse |
| launch_ungate_i | input | 1 | Forces the launch enable on |
| capture_ungate_i | input | 1 | Forces the capture enable on |
| ps_en_o | output | 1 | One-cycle phase step request |
| ps_inc_o | output | 1 | Step direction, 1 = increment |
| cap_sel_o | output | 1 | Capture-row clock select, 1 = shifted clock |
| launch_en_o | output | 1 | Launch-domain clock enable |
| capture_en_o | output | 1 | Capture-domain clock enable |
| flush_mode_o | output | 1 | Flush-delay mode active |
| ref_val_o | output | 1 | Latched flush reference value |
| ready_o | output | 1 | Idle, ready for a start pulse |

## Verification
A tracked phase that drifts from the clock manager's count shows up at the end of the same run. The bench's manager model then holds a phase different from the clamped request, and the next run issues the wrong number of steps or steps in the wrong direction. An off-by-one in the flush counter shows in the length of the `flush_mode_o` window and in which `chain_tail_i` bit ends up on `ref_val_o`. A sequencing fault shows up within a few cycles as a missing, doubled or misplaced launch/capture pair, a `cap_sel_o` outside those two cycles, or `ready_o` returning at the wrong cycle.

// File: rtl/lc_pkg.sv
package lc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FLUSH,
    ST_STEP,
    ST_WAIT,
    ST_LAUNCH,
    ST_CAPTURE
  } lc_state_e;

  // saturate a phase request at the legal upper bound
  function automatic logic [31:0] clamp_phase(logic [31:0] req, logic [31:0] lim);
    return (req > lim) ? lim : req;
  endfunction

  // next tracked phase after one acknowledged step
  function automatic logic [31:0] stepped_phase(logic [31:0] cur, logic up);
    return up ? cur + 32'd1 : cur - 32'd1;
  endfunction

endpackage

// File: rtl/lc_flush_timer.sv
module lc_flush_timer #(
  parameter int WAIT_CYC = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic last
);
  localparam int CW = (WAIT_CYC > 2) ? $clog2(WAIT_CYC) : 1;
  localparam logic [CW-1:0] LAST_CNT = CW'(WAIT_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else             cnt <= cnt + CW'(1);
  end

  assign last = run && (cnt == LAST_CNT);

  // R2
  flush_len_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !last) |=> run);
endmodule

// File: rtl/lc_phase_tracker.sv
module lc_phase_tracker #(
  parameter int PW   = 10,
  parameter int PMAX = 740
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step_ok,
  input  logic          up,
  output logic [PW-1:0] cur
);
  always_ff @(posedge clk) begin
    if (rst)          cur <= '0;
    else if (step_ok) cur <= PW'(lc_pkg::stepped_phase(32'(cur), up));
  end

  // R6
  phase_range_chk: assert property (@(posedge clk) disable iff (rst)
    32'(cur) <= 32'(PMAX));

  // R5
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    (step_ok && !up) |-> (cur != '0));
endmodule

// File: rtl/lc_phase_engine.sv
module lc_phase_engine #(
  parameter int PHASE_W    = 10,
  parameter int PHASE_MAX  = 740,
  parameter int FLUSH_WAIT = 128
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic [PHASE_W-1:0] req_phase_i,
  input  logic               chain_tail_i,
  input  logic               ps_done_i,
  input  logic               launch_ungate_i,
  input  logic               capture_ungate_i,
  output logic               ps_en_o,
  output logic               ps_inc_o,
  output logic               cap_sel_o,
  output logic               launch_en_o,
  output logic               capture_en_o,
  output logic               flush_mode_o,
  output logic               ref_val_o,
  output logic               ready_o
);
  import lc_pkg::*;

  lc_state_e          state;
  logic [PHASE_W-1:0] target_q;
  logic [PHASE_W-1:0] cur_phase;
  logic               ref_q;

  // named internal events
  logic flush_last;
  logic at_target;
  logic want_up;
  logic step_ok;
  logic launch_fire;
  logic capture_fire;

  assign at_target    = (cur_phase == target_q);
  assign want_up      = (target_q > cur_phase);
  assign step_ok      = (state == ST_WAIT) && ps_done_i;
  assign launch_fire  = (state == ST_LAUNCH);
  assign capture_fire = (state == ST_CAPTURE);

  lc_flush_timer #(.WAIT_CYC(FLUSH_WAIT)) u_flush (
    .clk  (clk),
    .rst  (rst),
    .run  (state == ST_FLUSH),
    .last (flush_last)
  );

  lc_phase_tracker #(.PW(PHASE_W), .PMAX(PHASE_MAX)) u_track (
    .clk     (clk),
    .rst     (rst),
    .step_ok (step_ok),
    .up      (want_up),
    .cur     (cur_phase)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      target_q <= '0;
      ref_q    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start_i) begin
          target_q <= PHASE_W'(clamp_phase(32'(req_phase_i), 32'(PHASE_MAX)));
          state    <= ST_FLUSH;
        end
        ST_FLUSH: if (flush_last) begin
          ref_q <= chain_tail_i;
          state <= ST_STEP;
        end
        ST_STEP:    state <= at_target ? ST_LAUNCH : ST_WAIT;
        ST_WAIT:    if (ps_done_i) state <= ST_STEP;
        ST_LAUNCH:  state <= ST_CAPTURE;
        ST_CAPTURE: state <= ST_IDLE;
        default:    state <= ST_IDLE;
      endcase
    end
  end

  assign ps_en_o      = (state == ST_STEP) && !at_target;
  assign ps_inc_o     = want_up;
  assign cap_sel_o    = launch_fire || capture_fire;
  assign launch_en_o  = launch_fire || launch_ungate_i;
  assign capture_en_o = capture_fire || capture_ungate_i;
  assign flush_mode_o = (state == ST_FLUSH);
  assign ref_val_o    = ref_q;
  assign ready_o      = (state == ST_IDLE);

  // R2
  flush_exit_chk: assert property (@(posedge clk) disable iff (rst)
    flush_last |=> (!flush_mode_o && !ready_o));

  // R4
  step_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    ps_en_o |=> !ps_en_o);

  // R4
  step_busy_chk: assert property (@(posedge clk) disable iff (rst)
    ps_en_o |-> (!ready_o && !flush_mode_o));

  // R7
  launch_then_capture_chk: assert property (@(posedge clk) disable iff (rst)
    launch_fire |=> capture_fire);

  // R8
  ready_after_capture_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ready_o) |-> $past(capture_fire));

  // R9
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (!ready_o && start_i) |=> $stable(target_q));

  // R3
  ref_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !flush_last |=> $stable(ref_val_o));
endmodule

// File: tb/lc_phase_engine_bench.sv
module lc_phase_engine_bench;
  localparam int PMAX  = 740;
  localparam int FWAIT = 128;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic [9:0] req_phase_i = '0;
  logic       chain_tail_i = 1'b0;
  logic       ps_done_i;
  logic       launch_ungate_i = 1'b0;
  logic       capture_ungate_i = 1'b0;
  logic       ps_en_o, ps_inc_o, cap_sel_o, launch_en_o, capture_en_o;
  logic       flush_mode_o, ref_val_o, ready_o;

  int total = 0;
  int fails = 0;
  int exp_phase = 0;

  // clock-manager model state
  int mgr_phase = 0;
  int pend = 0;
  bit pend_up = 1'b0;

  always #2 clk = ~clk;

  lc_phase_engine u_lc_phase_engine (
    .clk, .rst, .start_i, .req_phase_i, .chain_tail_i, .ps_done_i,
    .launch_ungate_i, .capture_ungate_i, .ps_en_o, .ps_inc_o, .cap_sel_o,
    .launch_en_o, .capture_en_o, .flush_mode_o, .ref_val_o, .ready_o
  );

  // phase counter with a delayed done pulse per step request
  always @(posedge clk) begin
    if (rst) begin
      mgr_phase <= 0;
      pend      <= 0;
      ps_done_i <= 1'b0;
    end else begin
      ps_done_i <= 1'b0;
      if (ps_en_o) begin
        pend    <= 1 + int'($urandom % 3);
        pend_up <= ps_inc_o;
      end else if (pend == 1) begin
        pend      <= 0;
        ps_done_i <= 1'b1;
        mgr_phase <= pend_up ? mgr_phase + 1 : mgr_phase - 1;
      end else if (pend > 1) begin
        pend <= pend - 1;
      end
    end
  end

  function automatic int bclamp(int r);
    return (r > PMAX) ? PMAX : r;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_once(int req, bit tail, bit poke);
    int tgt = bclamp(req);
    int prev = exp_phase;
    int flush_n = 0, inc_n = 0, dec_n = 0;
    int l_cnt = 0, c_cnt = 0, l_at = -1, c_at = -1, sel_bad = 0;
    int i = 0;
    chain_tail_i = tail;
    req_phase_i = 10'(req);
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    chk(ready_o == 1'b0, "R2", "ready after start", int'(ready_o), 0);
    while (ready_o == 1'b0 && i < 20000) begin
      if (poke && i == 20) begin
        start_i = 1'b1;
        req_phase_i = 10'((tgt + 333) % (PMAX + 1));
      end
      if (poke && i == 21) start_i = 1'b0;
      if (flush_mode_o) flush_n++;
      if (ps_en_o) begin
        if (ps_inc_o) inc_n++;
        else dec_n++;
      end
      if (launch_en_o) begin l_cnt++; l_at = i; end
      if (capture_en_o) begin c_cnt++; c_at = i; end
      if (cap_sel_o != (launch_en_o || capture_en_o)) sel_bad++;
      i++;
      @(negedge clk);
    end
    chk(i < 20000, "R8", "run finished", i, 0);
    chk(flush_n == FWAIT, "R2", "flush length", flush_n, FWAIT);
    chk(ref_val_o == tail, "R3", "reference value", int'(ref_val_o), int'(tail));
    chk(inc_n == ((tgt > prev) ? tgt - prev : 0), "R4", "increments", inc_n,
        (tgt > prev) ? tgt - prev : 0);
    chk(dec_n == ((prev > tgt) ? prev - tgt : 0), "R4", "decrements", dec_n,
        (prev > tgt) ? prev - tgt : 0);
    chk(mgr_phase == tgt, "R5", "manager phase", mgr_phase, tgt);
    chk(l_cnt == 1 && c_cnt == 1, "R7", "launch/capture pulses", l_cnt * 10 + c_cnt, 11);
    chk(c_at == l_at + 1, "R7", "capture after launch", c_at, l_at + 1);
    chk(sel_bad == 0, "R7", "capture select", sel_bad, 0);
    chk(i == c_at + 1, "R8", "ready return cycle", i, c_at + 1);
    if (poke) chk(mgr_phase == tgt, "R9", "busy start ignored", mgr_phase, tgt);
    exp_phase = tgt;
    // R3: reference holds while idle
    chain_tail_i = ~tail;
    repeat (3) @(negedge clk);
    chk(ref_val_o == tail, "R3", "reference held", int'(ref_val_o), int'(tail));
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(ready_o == 1'b1, "R1", "ready", int'(ready_o), 1);
    chk({ps_en_o, flush_mode_o, cap_sel_o, launch_en_o, capture_en_o, ref_val_o} == 6'b0,
        "R1", "idle outputs", int'({ps_en_o, flush_mode_o, cap_sel_o, launch_en_o,
        capture_en_o, ref_val_o}), 0);

    run_once(0, 1'b1, 1'b0);     // R5 zero steps
    run_once(5, 1'b0, 1'b0);
    run_once(740, 1'b1, 1'b0);   // R6 top of range
    run_once(3, 1'b1, 1'b0);
    run_once(1000, 1'b0, 1'b0);  // R6 clamp
    run_once(1023, 1'b1, 1'b0);  // R6 clamp, already there
    run_once(2, 1'b0, 1'b1);     // R9 start while busy

    // R10
    @(negedge clk) launch_ungate_i = 1'b1;
    #1 chk(launch_en_o == 1'b1 && capture_en_o == 1'b0, "R10", "launch ungate",
           int'({launch_en_o, capture_en_o}), 2);
    @(negedge clk) begin launch_ungate_i = 1'b0; capture_ungate_i = 1'b1; end
    #1 chk(launch_en_o == 1'b0 && capture_en_o == 1'b1, "R10", "capture ungate",
           int'({launch_en_o, capture_en_o}), 1);
    @(negedge clk) capture_ungate_i = 1'b0;

    // R11: reset mid-run, next run from zero
    req_phase_i = 10'd300;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    repeat (200) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(ready_o == 1'b1 && ps_en_o == 1'b0 && flush_mode_o == 1'b0, "R11", "idle after reset",
        int'({ready_o, ps_en_o, flush_mode_o}), 4);
    exp_phase = 0;
    run_once(4, 1'b1, 1'b0);

    for (int k = 0; k < 8; k++) begin
      run_once(int'($urandom % 1024), 1'($urandom), 1'(k % 3 == 0));
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule